// File: doc/BRIEF.md
# Second-stage delay-feedback butterfly with built-in minus-j rotation

This block is the second butterfly of a radix-2² pipelined FFT. It sits behind the first-stage butterfly and takes one complex sample per clock. A feedback line of N/4 complex words lets the stage pair each sample with the one that arrived a quarter frame earlier. Two control bits from the shared frame counter decide what happens in each cycle. In the store phase the stage parks the incoming sample in the line and releases what the line holds. In the butterfly phase it emits the sum of the line head and the incoming sample, and sends their difference back into the line.

In the last quarter of each frame the incoming sample is first multiplied by −j. This needs no multiplier. The real and imaginary parts are swapped and the new imaginary part is negated, with the negation clamped at the most negative code. General twiddle multiplication belongs to a later stage.

The output is registered and one bit wider than the input, so the sum and difference are always exact.

Top module: `bf2_stage`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the outputs and every feedback entry are cleared to zero. The first N/4 outputs after reset that come from the line are therefore zero.
- R2: When `sel_s` is 0 (store phase), the output takes the line head and the incoming sample is written into the line unrotated. The input value does not appear at the output that cycle.
- R3: When `sel_s` is 1 and `sel_t` is 0, the output takes head + x and the line receives head − x.
- R4: When `sel_s` and `sel_t` are both 1 (last quarter), x = a + jb is replaced by b − ja before the butterfly of R3. With any other `sel_s`/`sel_t` combination the sample is used unrotated.
- R5: In the rotation, negating the most negative W-bit code yields the most positive code, 2^(W−1) − 1.
- R6: A value written into the feedback line appears at its head exactly N/4 cycles later. This makes the butterfly differences emerge during the following store phase.
- R7: The output shows the result for the inputs sampled at a rising edge right after that edge, which is one cycle of latency.
- R8: The outputs are W+1 bits wide, and the sum and difference are exact for every pair of W-bit operands, the most negative code included.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_re | input | W | Incoming sample, real part, two's complement |
| in_im | input | W | Incoming sample, imaginary part, two's complement |
| sel_s | input | 1 | Phase bit: 0 store, 1 butterfly (counter bit log2(N)−2) |
| sel_t | input | 1 | Quarter bit: with `sel_s` selects the −j rotation (counter bit log2(N)−1) |
| out_re | output | W+1 | Stage output, real part |
| out_im | output | W+1 | Stage output, imaginary part |

## Verification
Every result is due one cycle after the edge that sampled its inputs. A butterfly difference comes out N/4 cycles after it was formed, one cycle after it reaches the line head. The bench drives on the falling edge and keeps a circular model of the line. At each falling edge it compares the output with the value it predicted one cycle earlier. A single nonzero sample is swept through every position of a frame, once with an ordinary value and once with the most negative code. This shows that the rotation touches only the last quarter and that the clamp acts there.

// File: rtl/bf2_pkg.sv
// Shared types for the second-stage butterfly.
// Assumes sel_s/sel_t come straight from the frame counter bits.
package bf2_pkg;

    typedef enum logic [1:0] {
        BF2_STORE   = 2'd0,
        BF2_ADD     = 2'd1,
        BF2_ADD_ROT = 2'd2
    } bf2_mode_e;

    // Map the two counter bits to the stage's operating mode.
    function automatic bf2_mode_e bf2_decode(input logic s, input logic t);
        if (!s) begin
            return BF2_STORE;
        end else if (t) begin
            return BF2_ADD_ROT;
        end
        return BF2_ADD;
    endfunction

endpackage

// File: rtl/bf2_rotate.sv
// Multiply-by-minus-j unit. It swaps the real and imaginary parts and negates
// the new imaginary part, clamping at the most negative code. It is purely
// combinational and assumes two's complement operands.
module bf2_rotate #(
    parameter int W = 16
) (
    input  logic                en,
    input  logic signed [W-1:0] a_re,
    input  logic signed [W-1:0] a_im,
    output logic signed [W-1:0] r_re,
    output logic signed [W-1:0] r_im
);
    localparam logic signed [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};
    localparam logic signed [W-1:0] SMAX = ~SMIN;

    logic signed [W-1:0] neg_re;

    // Saturating negation of the real part.
    always_comb begin
        if (a_re == SMIN) begin
            neg_re = SMAX;
        end else begin
            neg_re = -a_re;
        end
    end

    // Choose between the rotated and the plain sample.
    always_comb begin
        if (en) begin
            r_re = a_im;
            r_im = neg_re;
        end else begin
            r_re = a_re;
            r_im = a_im;
        end
    end
endmodule

// File: rtl/bf2_delay_line.sv
// Feedback line of DEPTH complex words, built as a shift register. A word
// written at one edge reaches the head DEPTH edges later. A synchronous
// active-low reset clears every tap. Assumes DEPTH >= 1.
module bf2_delay_line #(
    parameter int W     = 17,
    parameter int DEPTH = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic signed [W-1:0] wr_re,
    input  logic signed [W-1:0] wr_im,
    output logic signed [W-1:0] hd_re,
    output logic signed [W-1:0] hd_im
);
    logic signed [W-1:0] chain_re [DEPTH+1];
    logic signed [W-1:0] chain_im [DEPTH+1];

    assign chain_re[0] = wr_re;
    assign chain_im[0] = wr_im;

    for (genvar g = 0; g < DEPTH; g++) begin : g_tap
        logic signed [W-1:0] q_re;
        logic signed [W-1:0] q_im;

        // One tap: clear on reset, otherwise take the previous word.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q_re <= '0;
                q_im <= '0;
            end else begin
                q_re <= chain_re[g];
                q_im <= chain_im[g];
            end
        end

        assign chain_re[g+1] = q_re;
        assign chain_im[g+1] = q_im;
    end

    assign hd_re = chain_re[DEPTH];
    assign hd_im = chain_im[DEPTH];
endmodule

// File: rtl/bf2_core.sv
// Butterfly arithmetic and the output register. In store mode it forwards the
// line head and feeds back the sample. In the add modes it outputs head + x and
// feeds back head - x. Assumes the head holds a stored sample (within W bits)
// whenever an add mode is active, so the W+1 bit results are exact.
module bf2_core
    import bf2_pkg::*;
#(
    parameter int W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bf2_mode_e         mode,
    input  logic signed [W-1:0] x_re,
    input  logic signed [W-1:0] x_im,
    input  logic signed [W:0] h_re,
    input  logic signed [W:0] h_im,
    output logic signed [W:0] fb_re,
    output logic signed [W:0] fb_im,
    output logic signed [W:0] y_re,
    output logic signed [W:0] y_im
);
    logic signed [W:0] xe_re;
    logic signed [W:0] xe_im;
    logic signed [W:0] nxt_re;
    logic signed [W:0] nxt_im;

    assign xe_re = {x_re[W-1], x_re};
    assign xe_im = {x_im[W-1], x_im};

    // Select the output value and the feedback value for this cycle.
    always_comb begin
        if (mode == BF2_STORE) begin
            nxt_re = h_re;
            nxt_im = h_im;
            fb_re  = xe_re;
            fb_im  = xe_im;
        end else begin
            nxt_re = h_re + xe_re;
            nxt_im = h_im + xe_im;
            fb_re  = h_re - xe_re;
            fb_im  = h_im - xe_im;
        end
    end

    // Output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            y_re <= '0;
            y_im <= '0;
        end else begin
            y_re <= nxt_re;
            y_im <= nxt_im;
        end
    end

    AST_STORE_FORWARDS_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == BF2_STORE) |=> (y_re == $past(h_re) && y_im == $past(h_im))); // R2
endmodule

// File: rtl/bf2_stage.sv
// Top of the second radix-2^2 delay-feedback butterfly. sel_s/sel_t are the two
// top bits of the frame counter. The -j rotation is applied to the input when
// both are set, ahead of the butterfly. Assumes N is a power of two, N >= 4.
module bf2_stage
    import bf2_pkg::*;
#(
    parameter int N = 64,
    parameter int W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic signed [W-1:0] in_re,
    input  logic signed [W-1:0] in_im,
    input  logic              sel_s,
    input  logic              sel_t,
    output logic signed [W:0] out_re,
    output logic signed [W:0] out_im
);
    localparam int DEPTH = N / 4;
    localparam int OW    = W + 1;
    localparam logic signed [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};
    localparam logic signed [W-1:0] SMAX = ~SMIN;

    bf2_mode_e           mode;
    logic signed [W-1:0] rot_re;
    logic signed [W-1:0] rot_im;
    logic signed [OW-1:0] head_re;
    logic signed [OW-1:0] head_im;
    logic signed [OW-1:0] fb_re;
    logic signed [OW-1:0] fb_im;

    // Decode the counter bits into a mode.
    assign mode = bf2_decode(sel_s, sel_t);

    bf2_rotate #(.W(W)) i_rotate (
        .en   (mode == BF2_ADD_ROT),
        .a_re (in_re),
        .a_im (in_im),
        .r_re (rot_re),
        .r_im (rot_im)
    );

    bf2_delay_line #(.W(OW), .DEPTH(DEPTH)) i_line (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_re (fb_re),
        .wr_im (fb_im),
        .hd_re (head_re),
        .hd_im (head_im)
    );

    bf2_core #(.W(W)) i_core (
        .clk   (clk),
        .rst_n (rst_n),
        .mode  (mode),
        .x_re  (rot_re),
        .x_im  (rot_im),
        .h_re  (head_re),
        .h_im  (head_im),
        .fb_re (fb_re),
        .fb_im (fb_im),
        .y_re  (out_re),
        .y_im  (out_im)
    );

    // Widened copies for the sum-plus-difference check.
    logic signed [W+1:0] chk_out_re, chk_out_im, chk_fb_re, chk_fb_im, chk_h2_re, chk_h2_im;
    assign chk_out_re = {out_re[W], out_re};
    assign chk_out_im = {out_im[W], out_im};
    assign chk_fb_re  = {fb_re[W], fb_re};
    assign chk_fb_im  = {fb_im[W], fb_im};
    assign chk_h2_re  = {head_re, 1'b0};
    assign chk_h2_im  = {head_im, 1'b0};

    AST_ROT_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_s && sel_t) |-> (rot_re == in_im)); // R4
    AST_ROT_NEGATE: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_s && sel_t && in_re != SMIN) |-> (rot_im + in_re == 0)); // R4
    AST_ROT_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_s && sel_t && in_re == SMIN) |-> (rot_im == SMAX)); // R5
    AST_NO_ROT: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel_s && sel_t) |-> (rot_re == in_re && rot_im == in_im)); // R4
    AST_SUM_DIFF_RE: assert property (@(posedge clk) disable iff (!rst_n)
        sel_s |=> (chk_out_re + $past(chk_fb_re) == $past(chk_h2_re))); // R3
    AST_SUM_DIFF_IM: assert property (@(posedge clk) disable iff (!rst_n)
        sel_s |=> (chk_out_im + $past(chk_fb_im) == $past(chk_h2_im))); // R3
endmodule

// File: tb/test_bf2_stage.sv
`timescale 1ns/1ps
module test_bf2_stage;
    localparam int N  = 16;
    localparam int W  = 8;
    localparam int D  = N / 4;
    localparam int QB = $clog2(N);
    localparam int MINV = -(1 << (W - 1));
    localparam int MAXV = (1 << (W - 1)) - 1;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic              rst_n;
    logic signed [W-1:0] in_re, in_im;
    logic              sel_s, sel_t;
    logic signed [W:0] out_re, out_im;

    bf2_stage #(.N(N), .W(W)) i_bf2_stage (
        .clk(clk), .rst_n(rst_n), .in_re(in_re), .in_im(in_im),
        .sel_s(sel_s), .sel_t(sel_t), .out_re(out_re), .out_im(out_im)
    );

    int checks = 0;
    int fails  = 0;
    int ml_re [D];
    int ml_im [D];
    int ptr, cnt, since_rst;
    int exp_re, exp_im;
    bit have_exp;
    string exp_tag;
    logic [15:0] lfsr = 16'hACE1;

    task automatic check(input string tag, input int act, input int expv, input string what);
        checks++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
        end
    endtask

    // One cycle: check the prior prediction, then drive and predict this one.
    task automatic step(input int xr, input int xi);
        int s_b, t_b, ar, ai, hr, hi, fr, fi;
        if (have_exp) begin
            check(exp_tag, int'(out_re), exp_re, "re");
            check(exp_tag, int'(out_im), exp_im, "im");
        end
        s_b = (cnt >> (QB - 2)) & 1;
        t_b = (cnt >> (QB - 1)) & 1;
        ar = xr;
        ai = xi;
        if (s_b == 1 && t_b == 1) begin
            ar = xi;
            ai = (xr == MINV) ? MAXV : -xr;
        end
        hr = ml_re[ptr];
        hi = ml_im[ptr];
        if (s_b == 0) begin
            exp_re = hr; exp_im = hi; fr = ar; fi = ai;
            exp_tag = (since_rst < D) ? "R1 R2 R6" : "R2 R6";
        end else begin
            exp_re = hr + ar; exp_im = hi + ai; fr = hr - ar; fi = hi - ai;
            exp_tag = (t_b == 1) ? "R4 R3" : "R3";
            if (t_b == 1 && xr == MINV) exp_tag = {exp_tag, " R5"};
        end
        if (exp_re > MAXV || exp_re < MINV || exp_im > MAXV || exp_im < MINV)
            exp_tag = {exp_tag, " R8"};
        exp_tag = {exp_tag, " R7"};
        ml_re[ptr] = fr;
        ml_im[ptr] = fi;
        ptr = (ptr + 1) % D;
        in_re = xr[W-1:0];
        in_im = xi[W-1:0];
        sel_s = s_b[0];
        sel_t = t_b[0];
        have_exp = 1'b1;
        cnt = (cnt + 1) % N;
        since_rst++;
        @(negedge clk);
    endtask

    initial begin
        rst_n = 1'b0;
        in_re = 8'sd55; in_im = -8'sd77;
        sel_s = 1'b1; sel_t = 1'b0;
        repeat (3) @(negedge clk);
        check("R1", int'(out_re), 0, "reset re");
        check("R1", int'(out_im), 0, "reset im");
        rst_n = 1'b1;
        for (int k = 0; k < D; k++) begin ml_re[k] = 0; ml_im[k] = 0; end
        ptr = 0; cnt = 0; since_rst = 0; have_exp = 1'b0;
        // Single nonzero sample at every frame position, two values.
        for (int v = 0; v < 2; v++) begin
            for (int p = 0; p < N; p++) begin
                for (int k = 0; k < N; k++) begin
                    if (k == p) step(v == 0 ? 37 : MINV, v == 0 ? -90 : 100);
                    else step(0, 0);
                end
            end
        end
        // Extreme constant and alternating frames (R8 range, R5 clamp).
        for (int k = 0; k < N; k++) step(MINV, MINV);
        for (int k = 0; k < N; k++) step(MAXV, MAXV);
        for (int k = 0; k < N; k++) step((k % 2 == 0) ? MAXV : MINV, (k % 2 == 0) ? MINV : MAXV);
        for (int k = 0; k < N; k++) step((k % 2 == 0) ? MINV : MAXV, (k % 2 == 0) ? MAXV : MINV);
        // Pseudo-random frames.
        for (int k = 0; k < 40 * N; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(int'($signed(lfsr[7:0])), int'($signed(lfsr[15:8])));
        end
        // Flush the line.
        for (int k = 0; k < N + 1; k++) step(0, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL R7 watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule